// File: doc/BRIEF.md
# Timer Input Capture Unit

The unit watches one external input, brings it into the system clock domain through a two-flop synchronizer, and on a selected edge event copies the current value of one of two free-running 16-bit timer counters into a four-entry FIFO. A 3-bit mode field selects the edge type. It covers falling edges, rising edges, both edges, and every 4th or every 16th rising edge. The same field also offers an off setting and an interrupt-only setting. A 2-bit rate field sets how many stored captures make one interrupt pulse. Software configures the unit with a one-cycle write strobe and drains the FIFO with a read strobe. The popped value appears on a registered data output.

The unit reports a not-empty flag and an overflow flag. Once the FIFO holds four unread entries, later captures are dropped until software drains it. A stop-in-idle control lets the unit sleep while an idle input is high. In that state only the interrupt-only mode keeps raising wake requests.

Top module: `tcap_unit`

## Requirements
- R1: A level change on `cap_in` that is present at rising clock edge k is acted on at edge k+2. At that edge the selected timer value is stored, and `irq` and the flags are visible after that edge.
- R2: Mode 3'b011 captures on rising edges only, 3'b010 on falling edges only, and 3'b001 on both edges.
- R3: Mode 3'b100 captures on every 4th rising edge and 3'b101 on every 16th. The edge counter restarts from zero on every configuration write.
- R4: With `cfg_tsel`=1 the value of `tmr_a` is captured, and with `cfg_tsel`=0 the value of `tmr_b` is captured.
- R5: `cfg_rate` value n (0..3) raises `irq` on every (n+1)th stored capture. The capture counter restarts from zero on every configuration write.
- R6: In mode 3'b001 `cfg_rate` is ignored and every stored capture raises `irq`.
- R7: `rd_en` with a non-empty FIFO pops the oldest entry onto `rd_data` one edge later. `rd_en` with an empty FIFO leaves `rd_data` and all flags unchanged. `not_empty` is high while at least one entry is held.
- R8: A capture event while four entries are held or while `overflow` is set does the following: it sets `overflow`, stores nothing and raises no `irq`. `overflow` clears only when a read empties the FIFO, on an off-mode write or on reset.
- R9: A configuration write with mode 3'b000 or 3'b110 empties the FIFO and clears both flags. In those modes input edges have no effect.
- R10: Mode 3'b111 raises `irq` on each rising edge, ignores falling edges and never stores a capture.
- R11: While `idle`=1 with stop-in-idle set, only mode 3'b111 reacts to the input. With stop-in-idle clear, idle has no effect.
- R12: `irq` is a one-cycle pulse per interrupt event. An input event that falls in a configuration-write cycle is ignored.
- R13: After reset `rd_data`=0, `not_empty`=0, `overflow`=0, `irq`=0 and the mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode field to load |
| cfg_tsel | input | 1 | Timer select to load (1 = timer A) |
| cfg_rate | input | 2 | Captures-per-interrupt field to load |
| cfg_idle_stop | input | 1 | Stop-in-idle control to load |
| idle | input | 1 | System idle indication |
| tmr_a | input | 16 | Free-running timer A count |
| tmr_b | input | 16 | Free-running timer B count |
| cap_in | input | 1 | Asynchronous external capture input |
| rd_en | input | 1 | Pop request for the FIFO |
| rd_data | output | 16 | Last popped capture value |
| not_empty | output | 1 | FIFO holds at least one entry |
| overflow | output | 1 | A capture was lost to a full FIFO |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
An input change seen at one clock edge passes through the synchronizer and the edge register. Its capture, its `irq` pulse and its flag updates land two edges later. A pop lands on `rd_data` one edge after `rd_en`, and a configuration write takes effect at the edge that samples the strobe. The bench drives all inputs on the falling clock edge. A behavioural model built from queues and integers steps once per rising edge through the same two-edge input delay. Every output is compared with that model at each falling edge, half a cycle after the registers have settled.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [2:0] {
    MD_OFF    = 3'b000,
    MD_BOTH   = 3'b001,
    MD_FALL   = 3'b010,
    MD_RISE   = 3'b011,
    MD_RISE4  = 3'b100,
    MD_RISE16 = 3'b101,
    MD_RSVD   = 3'b110,
    MD_XINT   = 3'b111
  } cap_mode_e;

  // Off covers the explicit off code and the unused code.
  function automatic logic mode_is_off(cap_mode_e m);
    return (m == MD_OFF) || (m == MD_RSVD);
  endfunction

  // Number of qualifying edges per capture.
  function automatic int unsigned presc_ratio(cap_mode_e m);
    case (m)
      MD_RISE4:  return 4;
      MD_RISE16: return 16;
      default:   return 1;
    endcase
  endfunction

  // Edge that the mode counts toward a capture.
  function automatic logic qual_edge(cap_mode_e m, logic rise, logic fall);
    case (m)
      MD_BOTH:                       return rise | fall;
      MD_FALL:                       return fall;
      MD_RISE, MD_RISE4, MD_RISE16:  return rise;
      default:                       return 1'b0;
    endcase
  endfunction

  // Interrupt due for this stored capture, given the rate counter.
  function automatic logic rate_due(logic every_edge, int unsigned cnt, int unsigned rate);
    return every_edge || (cnt == rate);
  endfunction

endpackage

// File: rtl/tcap_edge_sync.sv
module tcap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/tcap_evt_sel.sv
module tcap_evt_sel
  import tcap_pkg::*;
#(
  parameter int MAX_RATIO = 16,
  localparam int PS_W = $clog2(MAX_RATIO)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cap_mode_e mode,
  input  logic      run,
  input  logic      clr,
  input  logic      rise,
  input  logic      fall,
  output logic      cap_evt,
  output logic      xint_evt
);
  logic [PS_W-1:0] pcnt;
  logic            qual;
  logic            multi;
  logic [PS_W-1:0] last;

  assign qual  = qual_edge(mode, rise, fall);
  assign multi = presc_ratio(mode) > 1;
  assign last  = PS_W'(presc_ratio(mode) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
    end else if (run && qual && multi) begin
      if (pcnt == last) pcnt <= '0;
      else              pcnt <= pcnt + 1'b1;
    end
  end

  assign cap_evt  = run && qual && (!multi || (pcnt == last));
  assign xint_evt = run && (mode == MD_XINT) && rise;
endmodule

// File: rtl/tcap_fifo.sv
module tcap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         overflow,
  output logic         stored,
  output logic         dropped
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          ovf_q;
  logic          full;
  logic          pop_ok;

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign dropped = push && (full || ovf_q);
  assign stored  = push && !full && !ovf_q;
  assign pop_ok  = pop && (cnt != '0) && !flush;

  always_ff @(posedge clk) begin
    if (stored && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
      rdata <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (stored) wp <= ptr_next(wp);
      if (pop_ok) begin
        rdata <= mem[rp];
        rp    <= ptr_next(rp);
      end
      case ({stored, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (pop_ok && cnt == CW'(1)) ovf_q <= 1'b0;
      else if (dropped)            ovf_q <= 1'b1;
    end
  end

  assign not_empty = (cnt != '0);
  assign overflow  = ovf_q;
endmodule

// File: rtl/tcap_irq_rate.sv
module tcap_irq_rate
  import tcap_pkg::*;
#(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              every_edge,
  input  logic [RATE_W-1:0] rate,
  input  logic              stored,
  input  logic              xint_evt,
  output logic              irq_set,
  output logic              irq
);
  logic [RATE_W-1:0] icnt;
  logic              due;

  assign due     = rate_due(every_edge, int'(icnt), int'(rate));
  assign irq_set = xint_evt || (stored && due);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= irq_set;
      if (clr) begin
        icnt <= '0;
      end else if (stored && !every_edge) begin
        if (icnt == rate) icnt <= '0;
        else              icnt <= icnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int DEPTH       = 4,
  parameter int RATE_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_RATIO   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_tsel,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_idle_stop,
  input  logic              idle,
  input  logic [TW-1:0]     tmr_a,
  input  logic [TW-1:0]     tmr_b,
  input  logic              cap_in,
  input  logic              rd_en,
  output logic [TW-1:0]     rd_data,
  output logic              not_empty,
  output logic              overflow,
  output logic              irq
);
  cap_mode_e         mode_q;
  logic              tsel_q;
  logic [RATE_W-1:0] rate_q;
  logic              sidl_q;

  // Named internal events
  logic          evt_lvl, evt_rise, evt_fall;
  logic          cap_evt, xint_evt;
  logic          cap_store, cap_drop, irq_set;
  logic          unit_run, cnt_clr, fifo_flush;
  logic [TW-1:0] tmr_pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_OFF;
      tsel_q <= 1'b0;
      rate_q <= '0;
      sidl_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q <= cap_mode_e'(cfg_mode);
      tsel_q <= cfg_tsel;
      rate_q <= cfg_rate;
      sidl_q <= cfg_idle_stop;
    end
  end

  assign fifo_flush = cfg_we && mode_is_off(cap_mode_e'(cfg_mode));
  assign cnt_clr    = cfg_we || mode_is_off(mode_q);
  assign unit_run   = !cfg_we && !mode_is_off(mode_q) &&
                      (!(sidl_q && idle) || (mode_q == MD_XINT));
  assign tmr_pick   = tsel_q ? tmr_a : tmr_b;

  tcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_in),
    .lvl  (evt_lvl),
    .rise (evt_rise),
    .fall (evt_fall)
  );

  tcap_evt_sel #(.MAX_RATIO(MAX_RATIO)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .run     (unit_run),
    .clr     (cnt_clr),
    .rise    (evt_rise),
    .fall    (evt_fall),
    .cap_evt (cap_evt),
    .xint_evt(xint_evt)
  );

  tcap_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (fifo_flush),
    .push     (cap_evt),
    .pop      (rd_en),
    .wdata    (tmr_pick),
    .rdata    (rd_data),
    .not_empty(not_empty),
    .overflow (overflow),
    .stored   (cap_store),
    .dropped  (cap_drop)
  );

  tcap_irq_rate #(.RATE_W(RATE_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .every_edge(mode_q == MD_BOTH),
    .rate      (rate_q),
    .stored    (cap_store),
    .xint_evt  (xint_evt),
    .irq_set   (irq_set),
    .irq       (irq)
  );
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_mode,
  input logic          idle,
  input logic          rd_en,
  input logic [TW-1:0] rd_data,
  input logic          not_empty,
  input logic          overflow,
  input logic          irq,
  input logic [2:0]    mode_q,
  input logic          sidl_q,
  input logic          cap_drop
);
  AST_DROP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cap_drop |=> !irq); // R8
  AST_OVF_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> not_empty); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !rd_en && !cfg_we) |=> overflow); // R8
  AST_OFF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_mode == 3'b000 || cfg_mode == 3'b110)) |=> (!not_empty && !overflow)); // R9
  AST_XINT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b111 && !cfg_we && !rd_en) |=> $stable(not_empty)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sidl_q && mode_q != 3'b111) |=> !irq); // R11
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !not_empty) |=> $stable(rd_data)); // R7
  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !irq); // R12
endmodule

bind tcap_unit tcap_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_mode (cfg_mode),
  .idle     (idle),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .not_empty(not_empty),
  .overflow (overflow),
  .irq      (irq),
  .mode_q   (mode_q),
  .sidl_q   (sidl_q),
  .cap_drop (cap_drop)
);

// File: tb/tb_tcap_unit.sv
`timescale 1ns/1ps
module tb_tcap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_mode = 3'b000;
  logic        cfg_tsel = 1'b0;
  logic [1:0]  cfg_rate = 2'b00;
  logic        cfg_idle_stop = 1'b0;
  logic        idle = 1'b0;
  logic [15:0] tmr_a = 16'h0000;
  logic [15:0] tmr_b = 16'h8000;
  logic        cap_in = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        not_empty, overflow, irq;

  int    n_checks = 0;
  int    n_errs   = 0;
  int    cyc      = 0;
  string cur_req  = "R13";
  bit    armed    = 0;

  always #2 clk = ~clk;

  tcap_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_tsel(cfg_tsel), .cfg_rate(cfg_rate), .cfg_idle_stop(cfg_idle_stop),
    .idle(idle), .tmr_a(tmr_a), .tmr_b(tmr_b), .cap_in(cap_in), .rd_en(rd_en),
    .rd_data(rd_data), .not_empty(not_empty), .overflow(overflow), .irq(irq)
  );

  // Free-running timers, advanced away from the active edge
  always @(negedge clk) begin
    tmr_a <= tmr_a + 16'd1;
    tmr_b <= tmr_b + 16'd7;
  end

  // Behavioural reference model
  int          m_mode = 0, m_rate = 0, m_pc = 0, m_ic = 0;
  bit          m_tsel = 0, m_sidl = 0, m_ov = 0, m_irq = 0;
  bit          m_s1 = 0, m_s2 = 0, m_prev = 0;
  logic [15:0] m_rd = 16'h0;
  logic [15:0] mq[$];

  always @(posedge clk) begin
    bit rise, fall, ev, irq_n, flush, is_off;
    int pre;
    armed = 1;
    cyc++;
    if (!rst_n) begin
      m_mode = 0; m_rate = 0; m_pc = 0; m_ic = 0; m_tsel = 0; m_sidl = 0;
      m_ov = 0; m_irq = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_rd = 0;
      mq.delete();
    end else begin
      rise = m_s2 && !m_prev;
      fall = !m_s2 && m_prev;
      irq_n = 0; flush = 0; ev = 0;
      pre = mq.size();
      if (cfg_we) begin
        m_mode = int'(cfg_mode); m_tsel = cfg_tsel; m_rate = int'(cfg_rate);
        m_sidl = cfg_idle_stop; m_pc = 0; m_ic = 0;
        if (m_mode == 0 || m_mode == 6) begin
          mq.delete(); m_ov = 0; flush = 1;
        end
      end else begin
        is_off = (m_mode == 0 || m_mode == 6);
        if (!is_off && (!(m_sidl && idle) || m_mode == 7)) begin
          case (m_mode)
            1: ev = rise || fall;
            2: ev = fall;
            3: ev = rise;
            4, 5: if (rise) begin
              m_pc++;
              if (m_pc == ((m_mode == 4) ? 4 : 16)) begin m_pc = 0; ev = 1; end
            end
            7: irq_n = rise;
            default: ev = 0;
          endcase
          if (ev) begin
            if (m_ov || pre == 4) m_ov = 1;
            else begin
              mq.push_back(m_tsel ? tmr_a : tmr_b);
              if (m_mode == 1) irq_n = 1;
              else if (m_ic == m_rate) begin irq_n = 1; m_ic = 0; end
              else m_ic++;
            end
          end
        end
      end
      if (rd_en && pre > 0 && !flush) begin
        m_rd = mq.pop_front();
        if (mq.size() == 0) m_ov = 0;
      end
      m_irq = irq_n;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = cap_in;
    end
  end

  // Compare against the model every cycle, half a period after the edge
  always @(negedge clk) begin
    if (armed) begin
      n_checks++;
      if (rd_data !== m_rd || not_empty !== (mq.size() > 0) ||
          overflow !== m_ov || irq !== m_irq) begin
        n_errs++;
        $display("FAIL %s cyc=%0d actual rd=%h ne=%b ov=%b irq=%b expected rd=%h ne=%b ov=%b irq=%b",
                 cur_req, cyc, rd_data, not_empty, overflow, irq,
                 m_rd, (mq.size() > 0), m_ov, m_irq);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog actual cyc=%0d expected end before 100000", cyc);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(int mode, bit tsel, int rate, bit sidl);
    @(negedge clk);
    cfg_we = 1; cfg_mode = 3'(mode); cfg_tsel = tsel;
    cfg_rate = 2'(rate); cfg_idle_stop = sidl;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulses(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cap_in = 1;
      wait_cyc(hi);
      cap_in = 0;
      wait_cyc(lo);
    end
  endtask

  task automatic reads(int n);
    @(negedge clk); rd_en = 1;
    wait_cyc(n);
    rd_en = 0;
  endtask

  task automatic expect_bit(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    wait_cyc(3);
    // R13: reset values
    expect_bit("R13", not_empty, 1'b0);
    expect_bit("R13", overflow, 1'b0);
    expect_bit("R13", irq, 1'b0);
    expect_bit("R13", rd_data == 16'h0, 1'b1);
    rst_n = 1;
    wait_cyc(4);

    cur_req = "R1 R2 R4";
    set_cfg(3, 1, 0, 0);
    pulses(3, 5, 5);
    reads(4);
    set_cfg(2, 0, 0, 0);
    pulses(3, 4, 6);
    reads(4);

    cur_req = "R6";
    set_cfg(1, 1, 3, 0);
    pulses(2, 3, 3);
    reads(5);

    cur_req = "R5";
    set_cfg(3, 0, 2, 0);
    pulses(4, 3, 3);
    reads(4);
    set_cfg(3, 0, 3, 0);
    pulses(4, 2, 3);
    reads(4);

    cur_req = "R3";
    set_cfg(4, 1, 0, 0);
    pulses(9, 2, 2);
    reads(3);
    set_cfg(5, 0, 0, 0);
    pulses(17, 2, 2);
    reads(2);
    set_cfg(4, 0, 0, 0);
    pulses(2, 2, 2);
    set_cfg(4, 0, 0, 0);
    pulses(4, 2, 2);
    reads(2);

    cur_req = "R8";
    set_cfg(3, 1, 0, 0);
    pulses(6, 3, 3);
    reads(2);
    pulses(1, 3, 3);
    reads(2);
    wait_cyc(2);
    pulses(2, 3, 3);

    cur_req = "R7";
    reads(5);
    wait_cyc(2);
    reads(2);

    cur_req = "R9";
    pulses(2, 3, 3);
    set_cfg(0, 1, 0, 0);
    pulses(2, 3, 3);
    reads(2);
    set_cfg(3, 1, 0, 0);
    pulses(5, 2, 2);
    set_cfg(6, 1, 0, 0);
    pulses(2, 3, 3);

    cur_req = "R10";
    set_cfg(7, 1, 1, 0);
    pulses(3, 4, 4);
    reads(1);

    cur_req = "R11";
    idle = 1;
    set_cfg(3, 1, 0, 1);
    pulses(3, 3, 3);
    set_cfg(7, 1, 0, 1);
    pulses(2, 3, 3);
    set_cfg(3, 1, 0, 0);
    pulses(2, 3, 3);
    idle = 0;
    reads(3);

    cur_req = "R12";
    set_cfg(1, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); cap_in = ~cap_in;
      if (i == 2) begin cfg_we = 1; cfg_mode = 3'b001; end
      else cfg_we = 0;
    end
    cfg_we = 0;
    wait_cyc(4);
    reads(5);
    wait_cyc(4);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule